// File: doc/BRIEF.md
# Windowed Watchdog With Keyed Service Register

This block is a windowed watchdog that counts instruction cycles, marked by a cycle-enable tick. Software configures and services it through a single 8-bit service word. Bits 7:6 select the window, bits 5:1 carry a fixed key (5'b01100), and bit 0 enables a clock monitor. The clock-frequency check itself lives elsewhere; this block only holds that enable bit and exports it.

The first keyed write after reset fixes the window and the monitor enable for good. Every later write is a service. A service is valid only when it repeats the stored window bits together with the key, and only when it falls between the lower limit and the upper limit of the window. An early service, a late service or a malformed write starts a fault. During a fault the active-low output is pulled low until the sampled pin level reads low. It then stays low for HOLD_CYC more ticks and is released. Once the pin reads high again, a fresh window starts.

Counting and write checking stop while the inhibit input (HALT/IDLE) is high. The whole watchdog is off while the option-disable input is 1.

Top module: `win_wdog`

## Requirements
- R1: After reset, wdog_n_o is 1, mon_en_o is 1, and rd_data_o reads 8'hC1: window select 2'b11 in bits 7:6, zeros in bits 5:1 and monitor enable 1 in bit 0.
- R2: The first write after reset with bits 5:1 equal to 5'b01100 loads the window select from bits 7:6 and the monitor enable from bit 0. It raises no fault whatever its timing, and it restarts the window.
- R3: A first write whose bits 5:1 differ from 5'b01100 drives wdog_n_o low on that edge. The register stays unconfigured and keeps reading 8'hC1.
- R4: After configuration, a write is a service only if bits 7:1 equal the stored window select followed by the key. Any other write faults. No later write changes the window select or the monitor enable.
- R5: A service that arrives when fewer than LOWER_CYC ticks have been counted since the window started faults. A service at exactly LOWER_CYC ticks is valid.
- R6: With window select s, the fault is raised on the edge of the 2^(BASE_LOG2+s)-th counted tick since the window started, if no valid service came first. With the defaults this gives 8k, 16k, 32k and 64k cycles.
- R7: A valid service restarts the window count from zero.
- R8: Once a fault is raised, wdog_n_o stays low for as long as pin_i reads 1. The edge that samples pin_i low is followed by HOLD_CYC counted ticks, after which wdog_n_o returns to 1. The next window starts on the edge that samples pin_i high.
- R9: Writes made while wdog_n_o is low change neither the configuration nor the output.
- R10: rd_data_o bits 5:1 always read zero.
- R11: While inhibit_i is 1, ticks are not counted and writes are ignored, so no fault can start.
- R12: While opt_disable_i is 1, wdog_n_o stays 1, nothing is counted and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One instruction cycle elapsed |
| wr_i | input | 1 | Service-register write strobe |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register readback, key field masked to zero |
| inhibit_i | input | 1 | HALT/IDLE: freeze counting and ignore writes |
| opt_disable_i | input | 1 | 1 turns the watchdog off |
| pin_i | input | 1 | Sampled level of the fault pin, already synchronous to clk |
| wdog_n_o | output | 1 | Active-low fault output, registered |
| mon_en_o | output | 1 | Stored clock-monitor enable |

## Verification
The assertions rely on three assumptions about the inputs: pin_i is already synchronous to clk, wdata_i is valid whenever wr_i is high, and opt_disable_i is a static option that does not toggle in the middle of a fault. The bench keeps to these assumptions by driving every input on the falling edge. In the random phase it ties pin_i to the expected output level of the previous cycle, which models the external wiring of the pin. The option input changes only during a directed segment while the output is idle. Random write spacing is set so that early services, in-window services, timeouts and key or window mismatches all occur with the small bench limits.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  typedef enum logic [1:0] {
    WD_RUN     = 2'd0,
    WD_PULL    = 2'd1,
    WD_HOLD    = 2'd2,
    WD_RELEASE = 2'd3
  } wd_state_e;

  localparam logic [4:0] WD_KEY     = 5'b01100;
  localparam logic [1:0] WD_SEL_RST = 2'b11;

  typedef struct packed {
    logic [1:0] win;
    logic [4:0] key;
    logic       mon;
  } wd_word_t;

endpackage

// File: rtl/wdw_write_decode.sv
module wdw_write_decode
  import wdw_pkg::*;
(
  input  logic [7:0] wdata_i,
  input  logic [1:0] sel_i,
  output logic       key_ok_o,
  output logic       full_ok_o,
  output logic [1:0] new_sel_o,
  output logic       new_mon_o
);

  wd_word_t word;

  assign word      = wd_word_t'(wdata_i);
  assign key_ok_o  = (word.key == WD_KEY);
  assign full_ok_o = key_ok_o && (word.win == sel_i);
  assign new_sel_o = word.win;
  assign new_mon_o = word.mon;

endmodule

// File: rtl/wdw_window_ctr.sv
module wdw_window_ctr #(
  parameter int LOWER_CYC = 256,
  parameter int BASE_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       cnt_en_i,
  input  logic [1:0] sel_i,
  output logic       early_o,
  output logic       expire_o
);

  localparam int CW = BASE_LOG2 + 4;
  localparam logic [CW-1:0] LOW_V = CW'(LOWER_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_last [4];

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_last[g] = (CW'(1) << (BASE_LOG2 + g)) - CW'(1);
  end

  assign early_o  = (cnt_q < LOW_V);
  assign expire_o = cnt_en_i && (cnt_q == lim_last[sel_i]);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (cnt_en_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_last[sel_i]); // R6

endmodule

// File: rtl/wdw_fault_seq.sv
module wdw_fault_seq
  import wdw_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic tick_en_i,
  input  logic err_i,
  input  logic pin_i,
  output logic fault_n_o,
  output logic running_o
);

  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  wd_state_e     state_q, state_d;
  logic [HW-1:0] hold_q, hold_d;

  assign running_o = (state_q == WD_RUN);

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    if (!enable_i) begin
      state_d = WD_RUN;
      hold_d  = '0;
    end else begin
      case (state_q)
        WD_RUN:     if (err_i) state_d = WD_PULL;
        WD_PULL:    if (!pin_i) begin
                      state_d = WD_HOLD;
                      hold_d  = '0;
                    end
        WD_HOLD:    if (tick_en_i) begin
                      if (hold_q == HOLD_LAST) state_d = WD_RELEASE;
                      else hold_d = hold_q + HW'(1);
                    end
        WD_RELEASE: if (pin_i) state_d = WD_RUN;
        default:    state_d = WD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WD_RUN;
      hold_q    <= '0;
      fault_n_o <= 1'b1;
    end else begin
      state_q   <= state_d;
      hold_q    <= hold_d;
      fault_n_o <= !((state_d == WD_PULL) || (state_d == WD_HOLD));
    end
  end

  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    hold_q < HW'(HOLD_CYC)); // R8

  AST_PULL_UNTIL_PIN: assert property (@(posedge clk) disable iff (rst)
    (state_q == WD_PULL && pin_i && enable_i) |=> !fault_n_o); // R8

endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdw_pkg::*;
#(
  parameter int LOWER_CYC = 256,
  parameter int BASE_LOG2 = 13,
  parameter int HOLD_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rd_data_o,
  input  logic       inhibit_i,
  input  logic       opt_disable_i,
  input  logic       pin_i,
  output logic       wdog_n_o,
  output logic       mon_en_o
);

  logic       enable, running, live_wr, cnt_en, tick_en;
  logic       key_ok, full_ok, early, expire;
  logic       svc_ok, err, clr;
  logic [1:0] new_sel;
  logic       new_mon;

  logic       cfg_q, cfg_d;
  logic [1:0] sel_q, sel_d;
  logic       mon_q, mon_d;

  assign enable  = !opt_disable_i;
  assign tick_en = tick_i && !inhibit_i;
  assign live_wr = wr_i && enable && !inhibit_i && running;
  assign cnt_en  = enable && tick_en && running;

  wdw_write_decode u_dec (
    .wdata_i   (wdata_i),
    .sel_i     (sel_q),
    .key_ok_o  (key_ok),
    .full_ok_o (full_ok),
    .new_sel_o (new_sel),
    .new_mon_o (new_mon)
  );

  assign svc_ok = live_wr && (cfg_q ? (full_ok && !early) : key_ok);
  assign err    = (live_wr && !svc_ok) || (expire && !svc_ok);
  assign clr    = !enable || !running || svc_ok || err;

  wdw_window_ctr #(
    .LOWER_CYC (LOWER_CYC),
    .BASE_LOG2 (BASE_LOG2)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr),
    .cnt_en_i (cnt_en),
    .sel_i    (sel_q),
    .early_o  (early),
    .expire_o (expire)
  );

  wdw_fault_seq #(
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable_i  (enable),
    .tick_en_i (tick_en),
    .err_i     (err),
    .pin_i     (pin_i),
    .fault_n_o (wdog_n_o),
    .running_o (running)
  );

  always_comb begin
    cfg_d = cfg_q;
    sel_d = sel_q;
    mon_d = mon_q;
    if (live_wr && !cfg_q && key_ok) begin
      cfg_d = 1'b1;
      sel_d = new_sel;
      mon_d = new_mon;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= 1'b0;
      sel_q     <= WD_SEL_RST;
      mon_q     <= 1'b1;
      rd_data_o <= {WD_SEL_RST, 5'b00000, 1'b1};
    end else begin
      cfg_q     <= cfg_d;
      sel_q     <= sel_d;
      mon_q     <= mon_d;
      rd_data_o <= {sel_d, 5'b00000, mon_d};
    end
  end

  assign mon_en_o = mon_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg_q |=> (sel_q == $past(sel_q)) && (mon_q == $past(mon_q))); // R4

  AST_EARLY_TRIPS: assert property (@(posedge clk) disable iff (rst)
    (wr_i && enable && !inhibit_i && running && cfg_q && early) |=> !wdog_n_o); // R5

  AST_INHIBIT_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
    (inhibit_i && wdog_n_o) |=> wdog_n_o); // R11

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    opt_disable_i |=> wdog_n_o); // R12

endmodule

// File: tb/win_wdog_bench.sv
`timescale 1ns/1ps
module win_wdog_bench;

  localparam int LOW  = 16;
  localparam int BASE = 6;
  localparam int HOLD = 16;
  localparam logic [4:0] KEY = 5'b01100;

  logic       clk = 1'b0;
  logic       rst, tick, wr, inhibit, opt_dis, pin;
  logic [7:0] wdata;
  logic [7:0] rd_data;
  logic       wdog_n, mon_en;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  win_wdog #(.LOWER_CYC(LOW), .BASE_LOG2(BASE), .HOLD_CYC(HOLD)) u_win_wdog (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_i(wr), .wdata_i(wdata),
    .rd_data_o(rd_data), .inhibit_i(inhibit), .opt_disable_i(opt_dis),
    .pin_i(pin), .wdog_n_o(wdog_n), .mon_en_o(mon_en)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int limit_of(logic [1:0] s);
    return 1 << (BASE + s);
  endfunction

  int         m_st, m_cnt, m_hold;
  bit         m_cfg, m_mon;
  logic [1:0] m_sel;

  function automatic logic exp_out();
    return !(m_st == 1 || m_st == 2);
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_hold = 0; m_cfg = 0; m_sel = 2'b11; m_mon = 1;
  endtask

  task automatic model_step(bit w, logic [7:0] d, bit t, bit inh, bit p);
    bit en, err, svc;
    en = t && !inh; err = 0; svc = 0;
    case (m_st)
      0: begin
        if (w && !inh) begin
          if (!m_cfg) begin
            if (d[5:1] == KEY) begin
              m_cfg = 1; m_sel = d[7:6]; m_mon = d[0]; svc = 1;
            end else err = 1;
          end else if (d[7:1] == {m_sel, KEY} && m_cnt >= LOW) svc = 1;
          else err = 1;
        end
        if (!err && !svc && en && m_cnt == limit_of(m_sel) - 1) err = 1;
        if (err) begin m_st = 1; m_cnt = 0; end
        else if (svc) m_cnt = 0;
        else if (en) m_cnt++;
      end
      1: if (!p) begin m_st = 2; m_hold = 0; end
      2: if (en) begin
           if (m_hold == HOLD - 1) m_st = 3; else m_hold++;
         end
      default: if (p) begin m_st = 0; m_cnt = 0; end
    endcase
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_word(logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic recover();
    pin = 1'b0;
    wait_n(HOLD + 2);
    pin = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    rst = 1'b1; tick = 1'b1; wr = 1'b0; wdata = 8'h00;
    inhibit = 1'b0; opt_dis = 1'b0; pin = 1'b1;
    @(negedge clk);
    do_reset();

    // R1 / R10 reset state
    check("R1 out", 8'(wdog_n), 8'h01);
    check("R1 rd", rd_data, 8'hC1);
    check("R1 mon", 8'(mon_en), 8'h01);

    // R3 bad key on first write
    wr_word({2'b00, 5'b10101, 1'b0});
    check("R3 fault", 8'(wdog_n), 8'h00);
    check("R3 unconfigured", rd_data, 8'hC1);
    recover();

    // R2 keyed first write right at window start
    wr_word({2'b00, KEY, 1'b0});
    check("R2 no fault", 8'(wdog_n), 8'h01);
    check("R2 readback", rd_data, 8'h00);
    check("R2 mon", 8'(mon_en), 8'h00);
    check("R10 key hidden", 8'(rd_data[5:1]), 8'h00);

    // R5 service right after the first write is early
    wr_word({2'b00, KEY, 1'b0});
    check("R5 early", 8'(wdog_n), 8'h00);
    recover();

    // R5 boundary: exactly LOW ticks valid, LOW-1 faults
    wait_n(LOW);
    wr_word({2'b00, KEY, 1'b1});
    check("R5 at lower limit", 8'(wdog_n), 8'h01);
    check("R4 mon frozen", 8'(mon_en), 8'h00);
    wait_n(LOW - 1);
    wr_word({2'b00, KEY, 1'b0});
    check("R5 one below lower", 8'(wdog_n), 8'h00);
    recover();

    // R4 window mismatch, R9 writes ignored during fault
    wait_n(20);
    wr_word({2'b11, KEY, 1'b0});
    check("R4 mismatch fault", 8'(wdog_n), 8'h00);
    check("R4 config kept", rd_data, 8'h00);
    wr_word({2'b11, KEY, 1'b1});
    check("R9 write ignored rd", rd_data, 8'h00);
    check("R9 write ignored out", 8'(wdog_n), 8'h00);

    // R8 held low while pin reads high
    wait_n(5);
    check("R8 waits for pin", 8'(wdog_n), 8'h00);
    pin = 1'b0;
    for (int k = 0; k < HOLD; k++) begin
      @(negedge clk);
      check("R8 hold low", 8'(wdog_n), 8'h00);
    end
    @(negedge clk);
    check("R8 released", 8'(wdog_n), 8'h01);
    wait_n(3);
    check("R8 stays released", 8'(wdog_n), 8'h01);
    pin = 1'b1;
    @(negedge clk);

    // R6 timeout at 2^(BASE+0)
    wait_n(limit_of(2'b00) - 1);
    check("R6 before upper", 8'(wdog_n), 8'h01);
    @(negedge clk);
    check("R6 upper expired", 8'(wdog_n), 8'h00);
    recover();

    // R7 valid service restarts window
    wait_n(39);
    wr_word({2'b00, KEY, 1'b0});
    wait_n(limit_of(2'b00) - 1);
    check("R7 restarted", 8'(wdog_n), 8'h01);
    @(negedge clk);
    check("R7 timeout after restart", 8'(wdog_n), 8'h00);
    recover();

    // R11 inhibit freezes counting and writes
    wait_n(10);
    inhibit = 1'b1;
    wait_n(150);
    wr_word(8'hFF);
    wait_n(49);
    check("R11 no fault", 8'(wdog_n), 8'h01);
    check("R11 write ignored", rd_data, 8'h00);
    inhibit = 1'b0;
    wait_n(limit_of(2'b00) - 11);
    check("R11 count resumed", 8'(wdog_n), 8'h01);
    @(negedge clk);
    check("R11 timeout after resume", 8'(wdog_n), 8'h00);
    recover();

    // R12 disabled
    opt_dis = 1'b1;
    wait_n(300);
    check("R12 quiet", 8'(wdog_n), 8'h01);
    wr_word(8'hFF);
    check("R12 write ignored out", 8'(wdog_n), 8'h01);
    check("R12 write ignored rd", rd_data, 8'h00);
    opt_dis = 1'b0;
    @(negedge clk);

    // Random phase against bench model
    do_reset();
    model_reset();
    for (int i = 0; i < 4000; i++) begin
      bit t, inh, w, p;
      int r;
      logic [7:0] d;
      check("R6 R8 random out", 8'(wdog_n), 8'(exp_out()));
      check("R4 R10 random rd", rd_data, {m_sel, 5'b00000, m_mon});
      t   = ($urandom % 100) < 85;
      inh = ($urandom % 100) < 3;
      w   = ($urandom % 100) < 5;
      r   = $urandom % 100;
      if (m_cfg) d = (r < 80) ? {m_sel, KEY, 1'($urandom % 2)} : 8'($urandom);
      else       d = (r < 85) ? {2'($urandom % 4), KEY, 1'($urandom % 2)} : 8'($urandom);
      p = exp_out();
      tick = t; inhibit = inh; wr = w; wdata = d; pin = p;
      model_step(w, d, t, inh, p);
      @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule